// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block is an 8-bit timer/counter with one compare register and one waveform output. The counter can run in four waveform modes: a free-running overflow mode, a clear-on-match (CTC) mode, a single-slope fast PWM mode and a dual-slope phase-correct PWM mode. The counter advances once per tick. Ticks come from a free-running prescaler, and a 3-bit clock select field picks the division ratio.

A 2-bit output action field decides what a compare match does to the output. In the non-PWM modes a match can toggle, clear or set the output. In fast PWM the field also fixes the action at the top of the count. In phase-correct PWM the action depends on the count direction. When the compare value sits at the counter maximum and the upper action bit is set, the match is ignored and the action is taken at the top instead.

Software writes a configuration word (mode, output action and clock select) and, separately, the compare value. In the PWM modes the compare value is double-buffered. A pin-enable input is combined with the action field to decide whether the waveform reaches the pin.

Top module: `timer_wavegen`

## Requirements
- R1: In the clock cycle after a synchronous reset, the waveform level is 0, the counter, prescaler and compare value are 0, and the configuration is mode 00, action 00, clock select 000. With this state both wave_out and wave_conn are 0.
- R2: The prescaler is a 10-bit counter that increments every clock. Clock select 000 produces no ticks. Codes 001 to 111 tick when the low 0, 3, 5, 6, 7, 8 or 10 bits of the prescaler are all ones, which divides the clock by 1, 8, 32, 64, 128, 256 and 1024. The counter changes only on a tick.
- R3: In mode 00 (normal) the counter counts up and wraps from 0xFF to 0. On a tick where the count equals the compare value, action 01 toggles the output, 10 clears it and 11 sets it. Action 00 leaves it unchanged.
- R4: In mode 10 (CTC) the counter goes to 0 on the tick where it equals the compare value and counts up otherwise, wrapping through 0xFF. Compare actions are the same as in R3.
- R5: In modes 00 and 10 a compare write takes effect in the following cycle.
- R6: In mode 11 (fast PWM) the counter counts up and wraps at 0xFF. On the tick at count 0xFF, action 10 sets the output and action 11 clears it. On any other tick whose count equals the compare value, action 10 clears the output and action 11 sets it.
- R7: In mode 11 the compare write goes to a buffer. The active value loads from the buffer on the tick where the count wraps from 0xFF to 0. A write in that same cycle loads directly.
- R8: In mode 01 (phase-correct PWM) the counter counts up to 0xFF and then down to 0, turning at each end without repeating the end value. On a matching tick, action 10 clears the output while counting up and sets it while counting down. Action 11 does the opposite.
- R9: In mode 01 the active compare value loads from the buffer on the tick at count 0xFF while counting up. A write in that same cycle loads directly.
- R10: In a PWM mode with compare value 0xFF and action 10 or 11, the match is ignored. On the tick at count 0xFF, action 10 sets the output and action 11 clears it.
- R11: In a PWM mode, action 01 leaves the output level unchanged.
- R12: wave_conn is 1 exactly when the action field is nonzero and pin_oe is 1. wave_out equals the waveform level while wave_conn is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads cfg_mode, cfg_act and cfg_cs |
| cfg_mode | input | 2 | Waveform mode: 00 normal, 01 phase-correct, 10 CTC, 11 fast PWM |
| cfg_act | input | 2 | Compare output action field |
| cfg_cs | input | 3 | Clock select |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_data | input | 8 | Compare value written |
| pin_oe | input | 1 | Pin direction set to output |
| wave_out | output | 1 | Waveform pin value |
| wave_conn | output | 1 | Waveform drives the pin |

## Verification
The hardest case to reach from the ports is a compare write that lands in the same cycle as the buffered load at the top of a PWM period, particularly when the value written is 0xFF. The stimulus therefore writes the compare register at a fixed interval that shares no factor with the period length, so over a long run the write falls on every phase of the count, including the load tick. The written values sweep through the range and include 0xFF. The prescaler ratios are exercised in CTC with a tiny compare value, so that each ratio produces several output toggles within a short run.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    localparam int CNT_W = 8;
    localparam int PSC_W = 10;

    typedef enum logic [1:0] {
        WG_NORMAL = 2'b00,
        WG_PHASE  = 2'b01,
        WG_CTC    = 2'b10,
        WG_FAST   = 2'b11
    } wg_mode_e;

    typedef enum logic [1:0] {
        OC_HOLD,
        OC_TOGGLE,
        OC_CLEAR,
        OC_SET
    } oc_act_e;

    // Per-tick view of the counter handed to the output stage
    typedef struct packed {
        logic tick;
        logic at_max;
        logic match;
        logic up;
        logic cmp_is_max;
    } cnt_evt_t;

    typedef struct packed {
        wg_mode_e   mode;
        logic [1:0] act;
        logic [2:0] cs;
    } wg_cfg_t;

    function automatic logic mode_is_pwm(wg_mode_e m);
        return (m == WG_PHASE) || (m == WG_FAST);
    endfunction

    // Number of low prescaler bits that must be all ones for a tick
    function automatic int psc_shift(logic [2:0] cs);
        case (cs)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

    // Action for non-PWM compare matches
    function automatic oc_act_e plain_act(logic [1:0] act);
        case (act)
            2'b01:   return OC_TOGGLE;
            2'b10:   return OC_CLEAR;
            2'b11:   return OC_SET;
            default: return OC_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/wg_prescaler.sv
module wg_prescaler
    import wavegen_pkg::*;
#(
    parameter int W = PSC_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cs,
    output logic       tick
);

    logic [W-1:0] psc_q;
    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) psc_q <= '0;
        else     psc_q <= psc_q + 1'b1;
    end

    always_comb begin
        mask = W'((1 << psc_shift(cs)) - 1);
        tick = (cs != 3'd0) && (&(psc_q | ~mask));
    end

    // R2: divide-by-one selection ticks every cycle
    a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (cs == 3'd1) |-> tick);

    // R2: a tick with divide-by-8 selected never repeats on the next cycle
    a_r2_div8_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && cs == 3'd2 && $stable(cs)) |=> !tick || cs != 3'd2);

endmodule

// File: rtl/wg_counter.sv
module wg_counter
    import wavegen_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wg_mode_e     mode,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_data,
    output cnt_evt_t     evt
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] ocr_q;
    logic [W-1:0] buf_q;
    logic         up_q;
    logic         pwm;
    logic         at_max;
    logic         load_now;

    always_comb begin
        pwm      = mode_is_pwm(mode);
        at_max   = (cnt_q == MAXV);
        load_now = tick && pwm && at_max && (mode == WG_FAST || up_q);
    end

    // Count sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            case (mode)
                WG_CTC: begin
                    cnt_q <= (cnt_q == ocr_q) ? '0 : cnt_q + ONE;
                    up_q  <= 1'b1;
                end
                WG_PHASE: begin
                    if (up_q) begin
                        if (at_max) begin
                            up_q  <= 1'b0;
                            cnt_q <= MAXV - ONE;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            up_q  <= 1'b1;
                            cnt_q <= ONE;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    cnt_q <= cnt_q + ONE;
                    up_q  <= 1'b1;
                end
            endcase
        end
    end

    // Compare register with buffer used by the PWM modes
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            ocr_q <= '0;
        end else begin
            if (cmp_we) buf_q <= cmp_data;
            if (cmp_we && (!pwm || load_now)) ocr_q <= cmp_data;
            else if (load_now)                ocr_q <= buf_q;
        end
    end

    always_comb begin
        evt.tick       = tick;
        evt.at_max     = at_max;
        evt.match      = (cnt_q == ocr_q);
        evt.up         = up_q;
        evt.cmp_is_max = (ocr_q == MAXV);
    end

    // R2: no tick, no count change
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R4: CTC returns to zero after the matching tick
    a_r4_ctc_clear: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == WG_CTC && cnt_q == ocr_q) |=> (cnt_q == '0));

    // R8: phase-correct turns at the bottom
    a_r8_turn_at_bottom: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == WG_PHASE && !up_q && cnt_q == '0) |=> (up_q && cnt_q == ONE));

    // R8: phase-correct turns at the top
    a_r8_turn_at_top: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == WG_PHASE && up_q && at_max) |=> (!up_q && cnt_q == MAXV - ONE));

    // R5: direct write in non-PWM modes
    a_r5_direct_write: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && !pwm) |=> (ocr_q == $past(cmp_data)));

    // R7, R9: buffered load at the period boundary
    a_r9_buffer_load: assert property (@(posedge clk) disable iff (rst)
        (load_now && !cmp_we) |=> (ocr_q == $past(buf_q)));

    // R7: buffered value does not leak into the active value mid-period
    a_r7_no_early_load: assert property (@(posedge clk) disable iff (rst)
        (pwm && !load_now) |=> $stable(ocr_q));

endmodule

// File: rtl/wg_output.sv
module wg_output
    import wavegen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wg_mode_e   mode,
    input  logic [1:0] act,
    input  cnt_evt_t   evt,
    output logic       oc
);

    logic    oc_q;
    oc_act_e op;

    // Pick the action for this tick
    always_comb begin
        op = OC_HOLD;
        if (evt.tick) begin
            case (mode)
                WG_FAST: begin
                    if (act[1]) begin
                        if (evt.at_max)     op = act[0] ? OC_CLEAR : OC_SET;
                        else if (evt.match) op = act[0] ? OC_SET : OC_CLEAR;
                    end
                end
                WG_PHASE: begin
                    if (act[1]) begin
                        if (evt.cmp_is_max) begin
                            if (evt.at_max) op = act[0] ? OC_CLEAR : OC_SET;
                        end else if (evt.match) begin
                            op = (evt.up == act[0]) ? OC_SET : OC_CLEAR;
                        end
                    end
                end
                default: begin
                    if (evt.match) op = plain_act(act);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= 1'b0;
        end else begin
            case (op)
                OC_TOGGLE: oc_q <= ~oc_q;
                OC_CLEAR:  oc_q <= 1'b0;
                OC_SET:    oc_q <= 1'b1;
                default:   oc_q <= oc_q;
            endcase
        end
    end

    assign oc = oc_q;

    // R3: the level only moves on a tick
    a_r3_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(oc_q));

    // R11: reserved code holds the level in PWM modes
    a_r11_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_is_pwm(mode) && act == 2'b01) |=> $stable(oc_q));

    // R6: fast PWM non-inverting sets at the top
    a_r6_fast_top_set: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && mode == WG_FAST && act == 2'b10 && evt.at_max) |=> oc_q);

    // R10: phase-correct with compare at max ignores the match below the top
    a_r10_phase_max_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode == WG_PHASE && act[1] && evt.cmp_is_max && !evt.at_max) |=> $stable(oc_q));

endmodule

// File: rtl/timer_wavegen.sv
module timer_wavegen
    import wavegen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_act,
    input  logic [2:0] cfg_cs,
    input  logic       cmp_we,
    input  logic [7:0] cmp_data,
    input  logic       pin_oe,
    output logic       wave_out,
    output logic       wave_conn
);

    wg_cfg_t  cfg_q;
    logic     tick;
    cnt_evt_t evt;
    logic     oc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: WG_NORMAL, act: 2'b00, cs: 3'b000};
        end else if (cfg_we) begin
            cfg_q <= '{mode: wg_mode_e'(cfg_mode), act: cfg_act, cs: cfg_cs};
        end
    end

    wg_prescaler #(.W(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .cs   (cfg_q.cs),
        .tick (tick)
    );

    wg_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (cfg_q.mode),
        .cmp_we   (cmp_we),
        .cmp_data (cmp_data),
        .evt      (evt)
    );

    wg_output u_out (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_q.mode),
        .act  (cfg_q.act),
        .evt  (evt),
        .oc   (oc)
    );

    always_comb begin
        wave_conn = (cfg_q.act != 2'b00) && pin_oe;
        wave_out  = wave_conn ? oc : 1'b0;
    end

    // R12: a disconnected pin never shows a high level
    a_r12_idle_pin_low: assert property (@(posedge clk) disable iff (rst)
        !wave_conn |-> !wave_out);

    // R1: the cycle after reset the pin is released
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!wave_conn && !wave_out));

endmodule

// File: tb/tb_timer_wavegen.sv
module tb_timer_wavegen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] cfg_act = 2'b00;
    logic [2:0] cfg_cs = 3'b000;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_data = 8'h00;
    logic       pin_oe = 1'b0;
    logic       wave_out;
    logic       wave_conn;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_psc, m_cnt, m_up, m_ocr, m_buf, m_oc, m_mode, m_act, m_cs;

    always #4 clk = ~clk;

    timer_wavegen dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_act(cfg_act), .cfg_cs(cfg_cs), .cmp_we(cmp_we),
        .cmp_data(cmp_data), .pin_oe(pin_oe),
        .wave_out(wave_out), .wave_conn(wave_conn)
    );

    function automatic int divisor(int cs);
        case (cs)
            1: return 1;
            2: return 8;
            3: return 32;
            4: return 64;
            5: return 128;
            6: return 256;
            default: return 1024;
        endcase
    endfunction

    // Reference model update at each edge, then compare 2 ns later
    always @(posedge clk) begin
        bit tk, pwm, ld;
        if (rst) begin
            m_psc = 0; m_cnt = 0; m_up = 1; m_ocr = 0; m_buf = 0;
            m_oc = 0; m_mode = 0; m_act = 0; m_cs = 0;
        end else begin
            tk  = (m_cs != 0) && ((m_psc % divisor(m_cs)) == divisor(m_cs) - 1);
            pwm = (m_mode == 1) || (m_mode == 3);
            ld  = tk && pwm && (m_cnt == 255) && (m_mode == 3 || m_up == 1);
            m_psc = (m_psc + 1) % 1024;
            if (tk) begin
                if (m_mode == 0 || m_mode == 2) begin
                    if (m_cnt == m_ocr) begin
                        if (m_act == 1) m_oc = 1 - m_oc;
                        else if (m_act == 2) m_oc = 0;
                        else if (m_act == 3) m_oc = 1;
                    end
                end else if (m_mode == 3) begin
                    if (m_act >= 2) begin
                        if (m_cnt == 255) m_oc = (m_act == 2) ? 1 : 0;
                        else if (m_cnt == m_ocr) m_oc = (m_act == 3) ? 1 : 0;
                    end
                end else begin
                    if (m_act >= 2) begin
                        if (m_ocr == 255) begin
                            if (m_cnt == 255) m_oc = (m_act == 2) ? 1 : 0;
                        end else if (m_cnt == m_ocr) begin
                            if (m_up == 1) m_oc = (m_act == 3) ? 1 : 0;
                            else           m_oc = (m_act == 2) ? 1 : 0;
                        end
                    end
                end
                if (m_mode == 1) begin
                    if (m_up == 1) begin
                        if (m_cnt == 255) begin m_up = 0; m_cnt = 254; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
                        else m_cnt = m_cnt - 1;
                    end
                end else if (m_mode == 2) begin
                    m_cnt = (m_cnt == m_ocr) ? 0 : (m_cnt + 1) % 256;
                    m_up = 1;
                end else begin
                    m_cnt = (m_cnt + 1) % 256;
                    m_up = 1;
                end
            end
            if (ld) m_ocr = m_buf;
            if (cmp_we) begin
                m_buf = cmp_data;
                if (!pwm || ld) m_ocr = cmp_data;
            end
            if (cfg_we) begin
                m_mode = cfg_mode; m_act = cfg_act; m_cs = cfg_cs;
            end
        end
        #2;
        if (!done) check_outputs();
    end

    task automatic check_outputs();
        bit ec, eo;
        ec = (m_act != 0) && pin_oe;
        eo = ec && (m_oc == 1);
        n_checks++;
        if (wave_conn !== ec || wave_out !== eo) begin
            n_fail++;
            $display("FAIL %s: wave_out=%0b wave_conn=%0b expected wave_out=%0b wave_conn=%0b",
                     cur_req, wave_out, wave_conn, eo, ec);
        end
    endtask

    task automatic cfg(input int mode, input int act, input int cs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_act = 2'(act); cfg_cs = 3'(cs);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wcmp(input int v);
        @(negedge clk);
        cmp_we = 1'b1; cmp_data = 8'(v);
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Writes every 37 cycles so the write phase walks across the whole period
    task automatic sweep(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            wcmp((seed + k * 53) % 256);
            if (k % 7 == 3) wcmp(255);
            run(35);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
        finish_run();
    end

    initial begin
        run(3);
        rst = 1'b0;
        // R1: reset state, with pin enabled but no action selected
        cur_req = "R1";
        pin_oe = 1'b1;
        run(20);

        // R3: normal mode, toggle / clear / set
        cur_req = "R3";
        wcmp(8'h40);
        cfg(0, 1, 1); run(700);
        cfg(0, 2, 1); run(300);
        cfg(0, 3, 1); run(300);
        cfg(0, 1, 1); wcmp(0); run(600);

        // R5: direct compare writes in normal and CTC
        cur_req = "R5";
        sweep(20, 7);

        // R4: CTC toggling, lowering compare below the count
        cur_req = "R4";
        wcmp(8'h10); cfg(2, 1, 1); run(200);
        wcmp(8'h05); run(200);
        cfg(2, 3, 1); run(50); cfg(2, 2, 1); run(50);
        cur_req = "R5";
        sweep(15, 11);

        // R6: fast PWM both polarities
        cur_req = "R6";
        wcmp(8'h80); cfg(3, 2, 1); run(800);
        cfg(3, 3, 1); run(600);
        // R7: buffered update across the wrap
        cur_req = "R7";
        cfg(3, 2, 1);
        sweep(120, 3);
        // R10: compare at max in fast PWM
        cur_req = "R10";
        wcmp(255); run(600);
        cfg(3, 3, 1); run(600);
        // R11: reserved code in fast PWM
        cur_req = "R11";
        wcmp(8'h20); cfg(3, 1, 1); run(700);

        // R8: phase-correct both polarities
        cur_req = "R8";
        wcmp(8'h60); cfg(1, 2, 1); run(1200);
        cfg(1, 3, 1); run(1200);
        // R9: buffered update at the top
        cur_req = "R9";
        cfg(1, 2, 1);
        sweep(150, 5);
        // R10: compare at max in phase-correct
        cur_req = "R10";
        wcmp(255); run(1200);
        cfg(1, 3, 1); run(1200);
        // R11: reserved code in phase-correct
        cur_req = "R11";
        wcmp(8'h33); cfg(1, 1, 1); run(1200);

        // R12: pin enable gating
        cur_req = "R12";
        cfg(2, 1, 1); wcmp(3);
        pin_oe = 1'b0; run(100);
        pin_oe = 1'b1; run(100);
        cfg(2, 0, 1); run(50);

        // R2: every clock select, including stop
        cur_req = "R2";
        cfg(2, 1, 0); wcmp(1); run(500);
        for (int c = 2; c <= 7; c++) begin
            cfg(2, 1, c);
            run(divisor(c) * 8 + 50);
        end
        cfg(2, 1, 0); run(300);

        finish_run();
    end

endmodule